// File: doc/BRIEF.md
# Reset Sequencer with Boot Vector Load

This block takes a small 4-bit microcontroller core through reset. While the external reset line is high, it holds the core in reset and clears the start address. Once the line drops, it waits for the oscillator to settle. The default settling time is 2^17 clocks, which is 31.25 ms at 4.194304 MHz. It then reads two bytes from the bottom of program memory. Those bytes supply the 14-bit start address and the memory-bank and register-bank enable flags. After that the block lets the core run, and it marks the first running cycle with a single-cycle pulse.

The block also records where the reset came from. If the core was in standby when reset arrived, data memory keeps its contents, apart from the small window 0F8H..0FDH, which is always lost. If reset arrived during normal running, data memory is treated as undefined. The block also drives constant reset values for the timer/event counter's modulo, count and mode registers, for its output enable and for its output flip-flop.

Top module: `rstseq_top`

## Requirements
- R1: The external reset input is active high and is asserted asynchronously. From the first rising clock edge after it goes high, `core_reset` is 1, and it stays 1 while the input stays high.
- R2: After the external reset drops between two clock edges, `core_reset` stays 1 through the first WAIT_CYCLES+4 rising edges. It goes to 0 at edge number WAIT_CYCLES+5. That count is two synchronizer stages, one cycle to leave the held state, WAIT_CYCLES wait cycles and two fetch cycles.
- R3: `core_release` is 1 for exactly one cycle, the first cycle in which `core_reset` is 0, and is 0 at all other times.
- R4: Each boot performs exactly two reads of program memory. The read of address 0 is issued in the last wait cycle, after edge WAIT_CYCLES+2. The read of address 1 is issued in the following cycle. `pm_rd` is 0 in all other cycles.
- R5: The memory returns each byte one cycle after its read. `pc[13:8]` is loaded from bits [5:0] of byte 0, and `pc[7:0]` is loaded from byte 1.
- R6: `mbe` is loaded from bit 7 of byte 0 and `rbe` from bit 6 of byte 0.
- R7: While held in reset, and throughout the wait, `pc`, `mbe` and `rbe` are 0.
- R8: When reset is taken while the core is running, `ram_kept` takes the value of `standby` at that clock edge. 1 means data memory is retained apart from 0F8H..0FDH; 0 means it is undefined. `ram_kept` does not change while the core runs.
- R9: If reset is taken before the sequence reaches the running state (during the wait or the fetch), `ram_kept` is left unchanged and the settling wait starts again from zero.
- R10: The timer reset outputs are constant: `tmr_modulo` = FFH, `tmr_count` = 0, `tmr_mode` = 0, `tmr_out_en` = 0 and `tmr_out_ff` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ext_reset | input | 1 | External reset, active high, asynchronous |
| standby | input | 1 | Core is in a standby mode (sampled when reset is taken) |
| pm_rd | output | 1 | Program-memory read strobe |
| pm_addr | output | PM_AW | Program-memory byte address |
| pm_data | input | 8 | Program-memory read data, valid one cycle after the read |
| core_reset | output | 1 | Core held in reset |
| core_release | output | 1 | One-cycle pulse on the first running cycle |
| pc | output | 14 | Start address loaded from the boot vector |
| mbe | output | 1 | Memory-bank enable flag from the boot vector |
| rbe | output | 1 | Register-bank enable flag from the boot vector |
| ram_kept | output | 1 | Data memory retained (except 0F8H..0FDH) across the last reset |
| tmr_modulo | output | TMR_W | Timer modulo register reset value |
| tmr_count | output | TMR_W | Timer count register reset value |
| tmr_mode | output | TMR_W | Timer mode register reset value |
| tmr_out_en | output | 1 | Timer output enable reset value |
| tmr_out_ff | output | 1 | Timer output flip-flop reset value |

## Verification
Boot vectors are chosen so that faults in the address and flag mapping show up:
- all zeros and all ones;
- byte 0 with only bit 7 set, and byte 0 with only bit 6 set, which separate `mbe` from `rbe`;
- byte 0 with its top two bits set over a nonzero low field, which shows that the flag bits do not leak into `pc[13:8]`;
- different low bytes in each vector, which expose a swap of byte 0 and byte 1.

Each vector is paired with a different `standby` level on the reset that comes before it, so the retention flag is checked for both values. Directed runs then take reset during the wait and during the fetch, with `standby` set opposite to the stored flag. These runs show that the flag is left alone and that the full settling time is counted again.

// File: rtl/rstseq_pkg.sv
`timescale 1ns/1ps
package rstseq_pkg;

    // Width of the program counter; the high part (PC_W-8 bits) comes from byte 0.
    localparam int PC_W    = 14;
    localparam int PC_HI_W = PC_W - 8;

    // Flag positions inside boot byte 0.
    localparam int MBE_BIT = 7;
    localparam int RBE_BIT = 6;

    typedef enum logic [2:0] {
        SQ_HELD     = 3'd0,
        SQ_WAIT     = 3'd1,
        SQ_FETCH_HI = 3'd2,
        SQ_FETCH_LO = 3'd3,
        SQ_RUN      = 3'd4
    } seq_state_e;

    typedef struct packed {
        seq_state_e        st;
        logic [PC_W-1:0]   pc;
        logic              mbe;
        logic              rbe;
        logic              kept;
        logic              rel;
    } seq_regs_t;

endpackage

// File: rtl/rstseq_sync.sv
`timescale 1ns/1ps
// Reset synchronizer: asynchronous assertion, release after STAGES edges.
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_in,
    output logic rst_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or posedge arst_in) begin
        if (arst_in) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], 1'b0};
        end
    end

    assign rst_out = chain_q[STAGES-1];
endmodule

// File: rtl/rstseq_settle_ctr.sv
`timescale 1ns/1ps
// Oscillator settling counter: counts enabled cycles, flags the last one.
module rstseq_settle_ctr #(
    parameter int LIMIT = 131072
) (
    input  logic clk,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (en) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign done = en && !clr && (cnt_q == LAST);
endmodule

// File: rtl/rstseq_top.sv
`timescale 1ns/1ps
// Reset sequencer: hold, settle, fetch two-byte boot vector, release.
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int WAIT_CYCLES = 131072,
    parameter int PM_AW       = 14,
    parameter int TMR_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  ext_reset,
    input  logic                  standby,
    output logic                  pm_rd,
    output logic [PM_AW-1:0]      pm_addr,
    input  logic [7:0]            pm_data,
    output logic                  core_reset,
    output logic                  core_release,
    output logic [PC_W-1:0]       pc,
    output logic                  mbe,
    output logic                  rbe,
    output logic                  ram_kept,
    output logic [TMR_W-1:0]      tmr_modulo,
    output logic [TMR_W-1:0]      tmr_count,
    output logic [TMR_W-1:0]      tmr_mode,
    output logic                  tmr_out_en,
    output logic                  tmr_out_ff
);
    localparam logic [PM_AW-1:0] VEC_HI_ADDR = PM_AW'(0);
    localparam logic [PM_AW-1:0] VEC_LO_ADDR = PM_AW'(1);

    logic      rst_sync;
    logic      wait_done;
    logic      wait_en;
    logic      wait_clr;
    seq_regs_t d, q;

    rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .arst_in (ext_reset),
        .rst_out (rst_sync)
    );

    assign wait_en  = (q.st == SQ_WAIT) && !rst_sync;
    assign wait_clr = (q.st != SQ_WAIT) || rst_sync;

    rstseq_settle_ctr #(.LIMIT(WAIT_CYCLES)) u_settle (
        .clk  (clk),
        .clr  (wait_clr),
        .en   (wait_en),
        .done (wait_done)
    );

    // Next-state computation.
    always_comb begin
        d     = q;
        d.rel = 1'b0;
        if (rst_sync) begin
            // Retention is decided only when the core was actually running.
            if (q.st == SQ_RUN) begin
                d.kept = standby;
            end
            d.st  = SQ_HELD;
            d.pc  = '0;
            d.mbe = 1'b0;
            d.rbe = 1'b0;
        end else begin
            unique case (q.st)
                SQ_HELD: begin
                    d.st = SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (wait_done) begin
                        d.st = SQ_FETCH_HI;
                    end
                end
                SQ_FETCH_HI: begin
                    d.pc[PC_W-1:8] = pm_data[PC_HI_W-1:0];
                    d.mbe          = pm_data[MBE_BIT];
                    d.rbe          = pm_data[RBE_BIT];
                    d.st           = SQ_FETCH_LO;
                end
                SQ_FETCH_LO: begin
                    d.pc[7:0] = pm_data;
                    d.st      = SQ_RUN;
                    d.rel     = 1'b1;
                end
                SQ_RUN: begin
                    d.st = SQ_RUN;
                end
                default: begin
                    d.st = SQ_HELD;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    // Read port: byte 0 is requested in the last wait cycle, byte 1 while byte 0 returns.
    assign pm_rd   = (q.st == SQ_WAIT && wait_done) || (q.st == SQ_FETCH_HI);
    assign pm_addr = (q.st == SQ_FETCH_HI) ? VEC_LO_ADDR : VEC_HI_ADDR;

    assign core_reset   = (q.st != SQ_RUN);
    assign core_release = q.rel;
    assign pc           = q.pc;
    assign mbe          = q.mbe;
    assign rbe          = q.rbe;
    assign ram_kept     = q.kept;

    // Timer/event counter reset values.
    assign tmr_modulo = '1;
    assign tmr_count  = '0;
    assign tmr_mode   = '0;
    assign tmr_out_en = 1'b0;
    assign tmr_out_ff = 1'b0;
endmodule

// File: rtl/rstseq_chk.sv
`timescale 1ns/1ps
module rstseq_chk #(
    parameter int PC_W  = 14,
    parameter int PM_AW = 14
) (
    input logic             clk,
    input logic             ext_reset,
    input logic             pm_rd,
    input logic [PM_AW-1:0] pm_addr,
    input logic             core_reset,
    input logic             core_release,
    input logic [PC_W-1:0]  pc,
    input logic             mbe,
    input logic             rbe,
    input logic             ram_kept
);
    // R3
    a_r3_release_single: assert property (@(posedge clk) disable iff (ext_reset)
        core_release |=> !core_release);

    // R3
    a_r3_release_on_entry: assert property (@(posedge clk) disable iff (ext_reset)
        core_release |-> (!core_reset && $past(core_reset)));

    // R4
    a_r4_first_read_addr0: assert property (@(posedge clk) disable iff (ext_reset)
        $rose(pm_rd) |-> (pm_addr == PM_AW'(0)));

    // R4
    a_r4_second_read_addr1: assert property (@(posedge clk) disable iff (ext_reset)
        $rose(pm_rd) |=> (pm_rd && pm_addr == PM_AW'(1)));

    // R4
    a_r4_two_reads_only: assert property (@(posedge clk) disable iff (ext_reset)
        (pm_rd && $past(pm_rd)) |=> !pm_rd);

    // R4
    a_r4_read_in_reset: assert property (@(posedge clk) disable iff (ext_reset)
        pm_rd |-> core_reset);

    // R7
    a_r7_vector_clear: assert property (@(posedge clk) disable iff (ext_reset)
        (core_reset && !pm_rd && !$past(pm_rd)) |-> (pc == '0 && !mbe && !rbe));

    // R8
    a_r8_kept_stable_run: assert property (@(posedge clk) disable iff (ext_reset)
        !core_reset |-> $stable(ram_kept));
endmodule

bind rstseq_top rstseq_chk #(.PC_W(rstseq_pkg::PC_W), .PM_AW(PM_AW)) u_chk (
    .clk          (clk),
    .ext_reset    (ext_reset),
    .pm_rd        (pm_rd),
    .pm_addr      (pm_addr),
    .core_reset   (core_reset),
    .core_release (core_release),
    .pc           (pc),
    .mbe          (mbe),
    .rbe          (rbe),
    .ram_kept     (ram_kept)
);

// File: tb/rstseq_top_tb.sv
`timescale 1ns/1ps
module rstseq_top_tb;
    localparam int W     = 20;
    localparam int PM_AW = 14;
    localparam int TMR_W = 8;
    localparam int NVEC  = 6;

    // {byte0, byte1, standby before boot, expected pc, expected mbe, expected rbe}
    localparam bit [32:0] VEC [NVEC] = '{
        {8'h00, 8'h00, 1'b0, 14'h0000, 1'b0, 1'b0},
        {8'hFF, 8'hFF, 1'b1, 14'h3FFF, 1'b1, 1'b1},
        {8'h80, 8'h5A, 1'b0, 14'h005A, 1'b1, 1'b0},
        {8'h41, 8'h23, 1'b1, 14'h0123, 1'b0, 1'b1},
        {8'h2A, 8'hC3, 1'b0, 14'h2AC3, 1'b0, 1'b0},
        {8'hD5, 8'h0F, 1'b1, 14'h150F, 1'b1, 1'b1}
    };

    logic             clk = 1'b0;
    logic             ext_reset = 1'b1;
    logic             standby = 1'b0;
    logic             pm_rd;
    logic [PM_AW-1:0] pm_addr;
    logic [7:0]       pm_data = 8'h00;
    logic             core_reset, core_release, mbe, rbe, ram_kept;
    logic [13:0]      pc;
    logic [TMR_W-1:0] tmr_modulo, tmr_count, tmr_mode;
    logic             tmr_out_en, tmr_out_ff;
    logic [7:0]       mem_b0 = 8'h00;
    logic [7:0]       mem_b1 = 8'h00;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    rstseq_top #(.WAIT_CYCLES(W), .PM_AW(PM_AW), .TMR_W(TMR_W)) u_dut (
        .clk          (clk),
        .ext_reset    (ext_reset),
        .standby      (standby),
        .pm_rd        (pm_rd),
        .pm_addr      (pm_addr),
        .pm_data      (pm_data),
        .core_reset   (core_reset),
        .core_release (core_release),
        .pc           (pc),
        .mbe          (mbe),
        .rbe          (rbe),
        .ram_kept     (ram_kept),
        .tmr_modulo   (tmr_modulo),
        .tmr_count    (tmr_count),
        .tmr_mode     (tmr_mode),
        .tmr_out_en   (tmr_out_en),
        .tmr_out_ff   (tmr_out_ff)
    );

    // Program memory model: synchronous read, one cycle of latency.
    always @(posedge clk) begin
        if (pm_rd) begin
            pm_data <= (pm_addr == 0) ? mem_b0 : (pm_addr == 1) ? mem_b1 : 8'h00;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_timer_vals();
        chk(tmr_modulo == 8'hFF, "R10", "tmr_modulo", 32'(tmr_modulo), 32'hFF);
        chk(tmr_count == 0 && tmr_mode == 0, "R10", "tmr_count|tmr_mode",
            {tmr_count, tmr_mode}, 0);
        chk(!tmr_out_en && !tmr_out_ff, "R10", "tmr_out_en|tmr_out_ff",
            {tmr_out_en, tmr_out_ff}, 0);
    endtask

    // Take reset with a given standby level; check entry and retention flag.
    task automatic take_reset(input logic sb, input logic exp_kept);
        @(negedge clk);
        standby   = sb;
        ext_reset = 1'b1;
        @(negedge clk);
        chk(core_reset === 1'b1, "R1", "core_reset after assert", 32'(core_reset), 1);
        chk(ram_kept === exp_kept, "R8", "ram_kept", 32'(ram_kept), 32'(exp_kept));
        repeat (3) @(negedge clk);
        chk(core_reset === 1'b1, "R1", "core_reset while held", 32'(core_reset), 1);
        chk(pc == 0 && !mbe && !rbe, "R7", "pc/mbe/rbe while held", {pc, mbe, rbe}, 0);
        standby = 1'b0;
    endtask

    // Release reset and follow the whole boot sequence.
    task automatic boot_check(input logic [7:0] b0, input logic [7:0] b1,
                              input logic [13:0] epc, input logic embe, input logic erbe);
        int nreads = 0;
        bit order_ok = 1'b1;
        mem_b0 = b0;
        mem_b1 = b1;
        @(negedge clk);
        ext_reset = 1'b0;
        for (int i = 1; i <= W + 5; i++) begin
            @(negedge clk);
            if (pm_rd) begin
                nreads++;
                if (!((i == W + 2 && pm_addr == 0) || (i == W + 3 && pm_addr == 1)))
                    order_ok = 1'b0;
            end
            if (i == 10) begin
                chk(pc == 0 && !mbe && !rbe, "R7", "pc/mbe/rbe during wait", {pc, mbe, rbe}, 0);
            end
            if (i == W + 4) begin
                chk(core_reset === 1'b1, "R2", "core_reset before release", 32'(core_reset), 1);
                chk(core_release === 1'b0, "R3", "release early", 32'(core_release), 0);
            end
        end
        chk(core_reset === 1'b0, "R2", "core_reset at release", 32'(core_reset), 0);
        chk(core_release === 1'b1, "R3", "release pulse", 32'(core_release), 1);
        chk(nreads == 2 && order_ok, "R4", "read count/order", nreads, 2);
        chk(pc == epc, "R5", "pc", 32'(pc), 32'(epc));
        chk(mbe == embe && rbe == erbe, "R6", "mbe|rbe", {mbe, rbe}, {embe, erbe});
        @(negedge clk);
        chk(core_release === 1'b0, "R3", "release pulse width", 32'(core_release), 0);
        chk(core_reset === 1'b0, "R2", "stays running", 32'(core_reset), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(core_reset === 1'b1, "R1", "core_reset at power-up", 32'(core_reset), 1);
        chk(pm_rd === 1'b0, "R4", "no read in reset", 32'(pm_rd), 0);
        chk(pc == 0 && !mbe && !rbe, "R7", "pc/mbe/rbe at power-up", {pc, mbe, rbe}, 0);
        check_timer_vals();
        boot_check(8'h00, 8'h00, 14'h0000, 1'b0, 1'b0);

        // Vector table: reset from running with the listed standby, then boot.
        for (int v = 0; v < NVEC; v++) begin
            take_reset(VEC[v][16], VEC[v][16]);
            boot_check(VEC[v][32:25], VEC[v][24:17], VEC[v][15:2], VEC[v][1], VEC[v][0]);
            chk(ram_kept === VEC[v][16], "R8", "ram_kept after boot", 32'(ram_kept),
                32'(VEC[v][16]));
        end

        // R9: reset during the wait leaves ram_kept alone and restarts the wait.
        take_reset(1'b1, 1'b1);
        @(negedge clk);
        ext_reset = 1'b0;
        repeat (W / 2 + 3) @(negedge clk);
        standby   = 1'b0;
        ext_reset = 1'b1;
        @(negedge clk);
        chk(core_reset === 1'b1, "R9", "core_reset after mid-wait reset", 32'(core_reset), 1);
        chk(ram_kept === 1'b1, "R9", "ram_kept after mid-wait reset", 32'(ram_kept), 1);
        boot_check(8'h93, 8'h6E, 14'h136E, 1'b1, 1'b0);

        // R9: reset during the fetch.
        take_reset(1'b0, 1'b0);
        mem_b0 = 8'hFF;
        mem_b1 = 8'hFF;
        @(negedge clk);
        ext_reset = 1'b0;
        repeat (W + 3) @(negedge clk);
        standby   = 1'b1;
        ext_reset = 1'b1;
        repeat (2) @(negedge clk);
        chk(ram_kept === 1'b0, "R9", "ram_kept after mid-fetch reset", 32'(ram_kept), 0);
        chk(pc == 0 && !mbe && !rbe, "R7", "vector cleared by mid-fetch reset", {pc, mbe, rbe}, 0);
        standby = 1'b0;
        boot_check(8'h3C, 8'h81, 14'h3C81, 1'b0, 1'b0);
        check_timer_vals();

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule